// File: doc/BRIEF.md
# Clock Control Register Block with Write Protection

This block is the register front end of a reset-and-clock controller. Software reaches five word-addressed registers over a simple 32-bit bus. A control word holds the internal multi-speed oscillator enable, its range selector and range code, and the external oscillator enable. A standby word holds a second range code. An interrupt-enable word and an interrupt-flag word sit beside them, and a write-one-to-clear word clears the flags. From these registers the block drives the oscillator enable lines, the active range index of the internal oscillator, that oscillator's nominal frequency in kHz, and one interrupt line.

Writes are checked against the live clock tree, so some of them only partly take effect. A range code outside the frequency table is refused, and the field keeps the value it had. The external oscillator cannot be switched off while the system clock runs from it, or while the PLL takes it as its source. Both of those conditions come in as input ports. Oscillator start-up is treated as instant. Each ready bit therefore mirrors its enable. When an enable goes from 0 to 1, the matching ready flag is raised if its interrupt is enabled.

Top module: `clkctl_regs`

## Requirements
- R1: After reset the block is in this state: internal oscillator on; selector (CTRL bit 3) = 0; both range codes = 6; range_idx = 6; int_freq_khz = 4000; external oscillator off; interrupt-enable and flag registers = 0; irq = 0.
- R2: range_idx takes the control range code (CTRL bits 7:4) when the selector CTRL bit 3 is 1. It takes the standby range code (STBY bits 11:8) when the selector is 0.
- R3: int_freq_khz maps range_idx 0..11 to 100, 200, 400, 800, 1000, 2000, 4000, 8000, 16000, 24000, 32000 and 48000 in that order. It is 0 while the internal oscillator is off.
- R4: A write that carries a range code of 12 or more into either range field leaves that field at its previous value. The other bits of the same write still take effect.
- R5: A write that clears the external enable (CTRL bit 16) has no effect on that bit while sys_clk_sts = 2'b10 or pll_src = 2'b11. Setting the bit is always accepted.
- R6: The ready bits read back as copies of their enables: CTRL bit 1 follows CTRL bit 0, and CTRL bit 17 follows CTRL bit 16.
- R7: IFLAG bit 0 is set when the internal enable goes from 0 to 1 while IEN bit 0 = 1. IFLAG bit 1 is set when the external enable goes from 0 to 1 while IEN bit 1 = 1.
- R8: Writing 1 to a bit of ICLR clears the same IFLAG bit. irq is the OR over both bits of IFLAG AND IEN.
- R9: Word addresses are CTRL = 0, STBY = 1, IEN = 2, IFLAG = 3 and ICLR = 4. A read strobe at a clock edge places that register on rd_data after that edge, holding the value it had before any write at the same edge. ICLR and unmapped addresses read 0. IFLAG is read-only.
- R10: int_osc_en equals CTRL bit 0 and ext_osc_en equals CTRL bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (3) | Word address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| sys_clk_sts | input | 2 | Current system clock source; 2'b10 means external oscillator |
| pll_src | input | 2 | PLL source select; 2'b11 means external oscillator |
| range_idx | output | RANGE_W (4) | Active internal oscillator range index |
| int_freq_khz | output | 16 | Nominal internal oscillator frequency in kHz |
| int_osc_en | output | 1 | Internal oscillator enable |
| ext_osc_en | output | 1 | External oscillator enable |
| irq | output | 1 | Interrupt request |

## Verification
Every register change reaches a port within one clock. A range code that slipped past the guard would show on range_idx and int_freq_khz right after the write edge. A lost or spurious flag would show on irq at the same time. A protection failure would drop ext_osc_en in the cycle after the refused write. Ready and flag bits that are only visible through the registers show on rd_data one edge after the read strobe. The reference model is therefore compared against every output on every cycle, so a divergence is caught within a cycle of its cause.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   // register word addresses
   localparam int ADDR_CTRL  = 0;
   localparam int ADDR_STBY  = 1;
   localparam int ADDR_IEN   = 2;
   localparam int ADDR_IFLAG = 3;
   localparam int ADDR_ICLR  = 4;

   // control word bit positions
   localparam int CTRL_INT_ON   = 0;
   localparam int CTRL_INT_RDY  = 1;
   localparam int CTRL_SEL      = 3;
   localparam int CTRL_CODE_LSB = 4;
   localparam int CTRL_EXT_ON   = 16;
   localparam int CTRL_EXT_RDY  = 17;
   localparam int STBY_CODE_LSB = 8;

   // interrupt source positions
   localparam int SRC_INT = 0;
   localparam int SRC_EXT = 1;
   localparam int NUM_SRC = 2;

   // nominal internal oscillator frequency in kHz per range index
   function automatic logic [15:0] range_khz(input int idx);
      logic [15:0] k;
      case (idx)
         0:  k = 16'd100;
         1:  k = 16'd200;
         2:  k = 16'd400;
         3:  k = 16'd800;
         4:  k = 16'd1000;
         5:  k = 16'd2000;
         6:  k = 16'd4000;
         7:  k = 16'd8000;
         8:  k = 16'd16000;
         9:  k = 16'd24000;
         10: k = 16'd32000;
         11: k = 16'd48000;
         default: k = 16'd0;
      endcase
      return k;
   endfunction
endpackage

// File: rtl/clkctl_range_guard.sv
// Range code register that refuses codes outside the frequency table (R4).
module clkctl_range_guard #(
   parameter int CODE_W     = 4,
   parameter int NUM_CODES  = 12,
   parameter int RESET_CODE = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_code,
   output logic [CODE_W-1:0] code
);
   logic code_ok;
   assign code_ok = (32'(wr_code) < 32'(NUM_CODES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                code <= CODE_W'(RESET_CODE);
      else if (wr_en && code_ok) code <= wr_code;
   end
endmodule

// File: rtl/clkctl_ext_guard.sv
// External oscillator enable with clock-tree lock (R5).
module clkctl_ext_guard #(
   parameter int SWS_W   = 2,
   parameter int SWS_EXT = 2,
   parameter int PLL_W   = 2,
   parameter int PLL_EXT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_on,
   input  logic [SWS_W-1:0] sys_clk_sts,
   input  logic [PLL_W-1:0] pll_src,
   output logic             ext_on,
   output logic             ext_rise
);
   logic in_use;
   assign in_use   = (sys_clk_sts == SWS_W'(SWS_EXT)) || (pll_src == PLL_W'(PLL_EXT));
   assign ext_rise = wr_en && wr_on && !ext_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ext_on <= 1'b0;
      else if (wr_en && (wr_on || !in_use)) ext_on <= wr_on;
   end
endmodule

// File: rtl/clkctl_irq.sv
// Ready flags, write-one-to-clear, and the combined request (R7, R8).
module clkctl_irq #(
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set,
   input  logic [NSRC-1:0] clr,
   input  logic [NSRC-1:0] ien,
   output logic [NSRC-1:0] flag,
   output logic            irq
);
   for (genvar i = 0; i < NSRC; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                flag[i] <= 1'b0;
         else if (set[i] && ien[i]) flag[i] <= 1'b1;
         else if (clr[i])           flag[i] <= 1'b0;
      end
   end

   assign irq = |(flag & ien);
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
   import clkctl_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int RANGE_W     = 4,
   parameter int NUM_RANGES  = 12,
   parameter int RESET_RANGE = 6,
   parameter int SWS_EXT     = 2,
   parameter int PLL_EXT     = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [31:0]        wr_data,
   output logic [31:0]        rd_data,
   input  logic [1:0]         sys_clk_sts,
   input  logic [1:0]         pll_src,
   output logic [RANGE_W-1:0] range_idx,
   output logic [15:0]        int_freq_khz,
   output logic               int_osc_en,
   output logic               ext_osc_en,
   output logic               irq
);
   // elaboration checks
   if (NUM_RANGES > (1 << RANGE_W)) begin : g_bad_range_w
      $error("clkctl_regs: NUM_RANGES does not fit RANGE_W");
   end
   if (RESET_RANGE >= NUM_RANGES) begin : g_bad_reset_range
      $error("clkctl_regs: RESET_RANGE outside table");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("clkctl_regs: ADDR_W too small for register map");
   end
   if (CTRL_CODE_LSB + RANGE_W > CTRL_EXT_ON || STBY_CODE_LSB + RANGE_W > 32) begin : g_bad_layout
      $error("clkctl_regs: range field overlaps other fields");
   end

   logic               sel_ctrl, sel_stby, sel_ien, sel_iclr;
   logic               wr_ctrl, wr_stby;
   logic [RANGE_W-1:0] ctrl_code, stby_code;
   logic               range_sel, int_on, ext_on, ext_rise, int_rise;
   logic [NUM_SRC-1:0] ien, flag, set_vec, clr_vec;
   logic [31:0]        rd_mux;

   assign sel_ctrl = (addr == ADDR_W'(ADDR_CTRL));
   assign sel_stby = (addr == ADDR_W'(ADDR_STBY));
   assign sel_ien  = (addr == ADDR_W'(ADDR_IEN));
   assign sel_iclr = (addr == ADDR_W'(ADDR_ICLR));
   assign wr_ctrl  = wr_en && sel_ctrl;
   assign wr_stby  = wr_en && sel_stby;

   clkctl_range_guard #(.CODE_W(RANGE_W), .NUM_CODES(NUM_RANGES), .RESET_CODE(RESET_RANGE)) u_ctrl_rng (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl),
      .wr_code(wr_data[CTRL_CODE_LSB +: RANGE_W]), .code(ctrl_code));

   clkctl_range_guard #(.CODE_W(RANGE_W), .NUM_CODES(NUM_RANGES), .RESET_CODE(RESET_RANGE)) u_stby_rng (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_stby),
      .wr_code(wr_data[STBY_CODE_LSB +: RANGE_W]), .code(stby_code));

   clkctl_ext_guard #(.SWS_W(2), .SWS_EXT(SWS_EXT), .PLL_W(2), .PLL_EXT(PLL_EXT)) u_ext (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wr_on(wr_data[CTRL_EXT_ON]),
      .sys_clk_sts(sys_clk_sts), .pll_src(pll_src), .ext_on(ext_on), .ext_rise(ext_rise));

   // internal oscillator enable, selector and interrupt enables
   assign int_rise = wr_ctrl && wr_data[CTRL_INT_ON] && !int_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_on    <= 1'b1;
         range_sel <= 1'b0;
         ien       <= '0;
      end else begin
         if (wr_ctrl) begin
            int_on    <= wr_data[CTRL_INT_ON];
            range_sel <= wr_data[CTRL_SEL];
         end
         if (wr_en && sel_ien) ien <= wr_data[NUM_SRC-1:0];
      end
   end

   always_comb begin
      set_vec          = '0;
      set_vec[SRC_INT] = int_rise;
      set_vec[SRC_EXT] = ext_rise;
      clr_vec          = (wr_en && sel_iclr) ? wr_data[NUM_SRC-1:0] : '0;
   end

   clkctl_irq #(.NSRC(NUM_SRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(clr_vec),
      .ien(ien), .flag(flag), .irq(irq));

   // outputs
   assign range_idx    = range_sel ? ctrl_code : stby_code;
   assign int_freq_khz = int_on ? range_khz(int'(range_idx)) : 16'd0;
   assign int_osc_en   = int_on;
   assign ext_osc_en   = ext_on;

   // read path
   always_comb begin
      rd_mux = '0;
      case (int'(addr))
         ADDR_CTRL: begin
            rd_mux[CTRL_INT_ON]                  = int_on;
            rd_mux[CTRL_INT_RDY]                 = int_on;
            rd_mux[CTRL_SEL]                     = range_sel;
            rd_mux[CTRL_CODE_LSB +: RANGE_W]     = ctrl_code;
            rd_mux[CTRL_EXT_ON]                  = ext_on;
            rd_mux[CTRL_EXT_RDY]                 = ext_on;
         end
         ADDR_STBY:  rd_mux[STBY_CODE_LSB +: RANGE_W] = stby_code;
         ADDR_IEN:   rd_mux[NUM_SRC-1:0]              = ien;
         ADDR_IFLAG: rd_mux[NUM_SRC-1:0]              = flag;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_mux;
   end
endmodule

// File: rtl/clkctl_regs_chk.sv
module clkctl_regs_chk #(
   parameter int ADDR_W     = 3,
   parameter int RANGE_W    = 4,
   parameter int NUM_RANGES = 12,
   parameter int SWS_EXT    = 2,
   parameter int PLL_EXT    = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [31:0]        wr_data,
   input logic [1:0]         sys_clk_sts,
   input logic [1:0]         pll_src,
   input logic [RANGE_W-1:0] range_idx,
   input logic [RANGE_W-1:0] ctrl_code,
   input logic [15:0]        int_freq_khz,
   input logic               int_osc_en,
   input logic               ext_osc_en,
   input logic [1:0]         ien,
   input logic [1:0]         flag,
   input logic               irq
);
   logic locked;
   assign locked = (sys_clk_sts == 2'(SWS_EXT)) || (pll_src == 2'(PLL_EXT));

   p_index_in_table_r2: assert property (@(posedge clk) disable iff (!rst_n)
      32'(range_idx) < 32'(NUM_RANGES));

   p_freq_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !int_osc_en |-> int_freq_khz == 16'd0);

   p_bad_code_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(0) && 32'(wr_data[4 +: RANGE_W]) >= 32'(NUM_RANGES))
      |=> $stable(ctrl_code));

   p_ext_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_osc_en && locked) |=> ext_osc_en);

   p_ext_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ext_osc_en) && $past(ien[1])) |-> flag[1]);

   p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == 2'b00) |-> !irq);
endmodule

bind clkctl_regs clkctl_regs_chk #(
   .ADDR_W(ADDR_W), .RANGE_W(RANGE_W), .NUM_RANGES(NUM_RANGES),
   .SWS_EXT(SWS_EXT), .PLL_EXT(PLL_EXT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
   .sys_clk_sts(sys_clk_sts), .pll_src(pll_src), .range_idx(range_idx),
   .ctrl_code(ctrl_code), .int_freq_khz(int_freq_khz), .int_osc_en(int_osc_en),
   .ext_osc_en(ext_osc_en), .ien(ien), .flag(flag), .irq(irq)
);

// File: tb/tb_clkctl_regs.sv
`timescale 1ns/1ps
module tb_clkctl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  sys_clk_sts = 2'b00, pll_src = 2'b00;
   logic [31:0] rd_data;
   logic [3:0]  range_idx;
   logic [15:0] int_freq_khz;
   logic        int_osc_en, ext_osc_en, irq;

   int    n_vec = 0, n_bad = 0;
   bit    done = 1'b0;
   string cur_tag = "R1";

   always #5 clk = ~clk;

   clkctl_regs dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .sys_clk_sts(sys_clk_sts),
      .pll_src(pll_src), .range_idx(range_idx), .int_freq_khz(int_freq_khz),
      .int_osc_en(int_osc_en), .ext_osc_en(ext_osc_en), .irq(irq));

   // ---------------- reference model ----------------
   int khz_tab[12] = '{100, 200, 400, 800, 1000, 2000, 4000, 8000, 16000, 24000, 32000, 48000};
   int m_ccode, m_scode, m_sel, m_int, m_ext, m_ien, m_flag;
   logic [31:0] m_rd;

   function automatic logic [31:0] m_read(input int a);
      logic [31:0] v = '0;
      case (a)
         0: begin
            v[0] = m_int[0]; v[1] = m_int[0]; v[3] = m_sel[0];
            v[7:4] = 4'(m_ccode); v[16] = m_ext[0]; v[17] = m_ext[0];
         end
         1: v[11:8] = 4'(m_scode);
         2: v[1:0]  = 2'(m_ien);
         3: v[1:0]  = 2'(m_flag);
         default: v = '0;
      endcase
      return v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ccode = 6; m_scode = 6; m_sel = 0; m_int = 1; m_ext = 0;
         m_ien = 0; m_flag = 0; m_rd = '0;
      end else begin
         if (rd_en) m_rd = m_read(int'(addr));
         if (wr_en) begin
            case (int'(addr))
               0: begin
                  m_sel = int'(wr_data[3]);
                  if (int'(wr_data[7:4]) < 12) m_ccode = int'(wr_data[7:4]);
                  if (wr_data[0] && m_int == 0 && (m_ien & 1) != 0) m_flag = m_flag | 1;
                  m_int = int'(wr_data[0]);
                  if (wr_data[16] && m_ext == 0 && (m_ien & 2) != 0) m_flag = m_flag | 2;
                  if (wr_data[16] || !(sys_clk_sts == 2'b10 || pll_src == 2'b11))
                     m_ext = int'(wr_data[16]);
               end
               1: if (int'(wr_data[11:8]) < 12) m_scode = int'(wr_data[11:8]);
               2: m_ien = int'(wr_data[1:0]);
               4: m_flag = m_flag & ~int'(wr_data[1:0]);
               default: ;
            endcase
         end
      end
   end

   task automatic check(input string what, input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", cur_tag, what, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         automatic int idx = (m_sel != 0) ? m_ccode : m_scode;
         check("R9 rd_data", rd_data, m_rd);
         check("R2 range_idx", range_idx, idx);
         check("R3 int_freq_khz", int_freq_khz, (m_int != 0) ? khz_tab[idx] : 0);
         check("R10 int_osc_en", int_osc_en, m_int);
         check("R5 ext_osc_en", ext_osc_en, m_ext);
         check("R8 irq", irq, ((m_flag & m_ien) != 0) ? 1 : 0);
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = 3'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a);
      @(negedge clk);
      rd_en = 1'b1; addr = 3'(a);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   function automatic logic [31:0] ctrl_word(input int on, input int sel, input int code, input int ext);
      logic [31:0] v = '0;
      v[0] = 1'(on); v[3] = 1'(sel); v[7:4] = 4'(code); v[16] = 1'(ext);
      return v;
   endfunction

   initial begin
      // R1: reset state compared while reset is held and after release
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(0); rd(1); rd(2); rd(3);

      // R2/R3 via standby field, R4 refusal
      cur_tag = "R2";
      wr(1, 32'h0000_0900); rd(1);
      cur_tag = "R4";
      wr(1, 32'h0000_0D00); rd(1);
      wr(1, 32'h0000_0F00); rd(1);

      // R2 control field selected, R4 on control field with selector still updated
      cur_tag = "R2";
      wr(0, ctrl_word(1, 1, 11, 0)); rd(0);
      cur_tag = "R4";
      wr(0, ctrl_word(1, 0, 12, 0)); rd(0);
      wr(0, ctrl_word(1, 1, 14, 0)); rd(0);

      // R3: every code through the control field, valid and invalid
      cur_tag = "R3";
      for (int c = 0; c < 16; c++) begin
         wr(0, ctrl_word(1, 1, c, 0));
         rd(0);
      end

      // R7/R6: external enable with interrupt enabled
      cur_tag = "R7";
      wr(2, 32'h3); rd(2);
      wr(0, ctrl_word(1, 1, 3, 1)); rd(0); rd(3);
      // re-write while on: no new rise
      wr(4, 32'h2); rd(3);
      wr(0, ctrl_word(1, 1, 3, 1)); rd(3);

      // R5: protection from system clock, then from PLL
      cur_tag = "R5";
      sys_clk_sts = 2'b10;
      wr(0, ctrl_word(1, 1, 3, 0)); rd(0);
      sys_clk_sts = 2'b01; pll_src = 2'b11;
      wr(0, ctrl_word(1, 1, 3, 0)); rd(0);
      pll_src = 2'b10;
      wr(0, ctrl_word(1, 1, 3, 0)); rd(0);
      // setting is always accepted even when locked
      sys_clk_sts = 2'b10;
      wr(0, ctrl_word(1, 1, 3, 1)); rd(0); rd(3);
      sys_clk_sts = 2'b00; pll_src = 2'b00;
      wr(0, ctrl_word(1, 1, 3, 0)); rd(0);

      // R6/R10: internal oscillator off then on, flag 0
      cur_tag = "R6";
      wr(0, ctrl_word(0, 1, 5, 0)); rd(0);
      cur_tag = "R7";
      wr(0, ctrl_word(1, 1, 5, 0)); rd(3);

      // R8: clears and enable masking
      cur_tag = "R8";
      wr(4, 32'h1); rd(3);
      wr(0, ctrl_word(0, 1, 5, 0));
      wr(0, ctrl_word(1, 1, 5, 1)); rd(3);
      wr(2, 32'h0); rd(3);
      wr(2, 32'h2);
      wr(4, 32'h3); rd(3);

      // R9: ICLR and unmapped addresses read 0; IFLAG write ignored
      cur_tag = "R9";
      wr(3, 32'h3); rd(3);
      rd(4); rd(5); rd(6); rd(7);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule